// File: doc/BRIEF.md
# Cascadable Modulo-N Up/Down Counter Stage

This block is one digit of a chained counter. It keeps a small count that runs from 0 up to MODULUS-1 (nine values, 0 to 8, by default) and moves by one step on each request pulse. The pulses are one clock wide and share the system clock with the register. A lone up pulse steps the count forward, a lone down pulse steps it back, and both at once clear it.

To build a wider counter, place several copies side by side. Connect each stage's carry to the next stage's up input and its borrow to the next stage's down input. Carry and borrow are combinational, so a wrap or a clear reaches every downstream stage in the same clock cycle. A clear command raises carry and borrow together, and each following stage sees that as its own clear. The count register starts at zero when the device powers up. The block has no reset pin.

Top module: `wrap_updn_stage`

## Requirements
- R1: The count output only ever takes values from 0 to MODULUS-1 (0 to 8 by default).
- R2: At power-up, before any request, the count reads 0 and carry and borrow are low.
- R3: With up=1 and down=0, a count below MODULUS-1 becomes count+1 after the next rising clock edge.
- R4: With up=1 and down=0, a count of MODULUS-1 becomes 0 after the edge. Carry is high during that cycle, and only when both conditions hold.
- R5: With down=1 and up=0, a count above 0 becomes count-1 after the next rising clock edge.
- R6: With down=1 and up=0, a count of 0 becomes MODULUS-1 after the edge. Borrow is high during that cycle, and only when both conditions hold.
- R7: With up=1 and down=1, the count becomes 0 after the edge, and carry and borrow are both high during that cycle.
- R8: With up=0 and down=0, the count holds and carry and borrow stay low.
- R9: In a chain where carry feeds the next stage's up input and borrow feeds its down input, wraps step the next stage in the same cycle. A clear empties every stage in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the count register is updated on the rising edge |
| step_up | input | 1 | One-cycle request to count up (clears when paired with step_dn) |
| step_dn | input | 1 | One-cycle request to count down (clears when paired with step_up) |
| count | output | $clog2(MODULUS) | Present count value |
| carry | output | 1 | Combinational: up wrap or clear; drives the next stage's step_up |
| borrow | output | 1 | Combinational: down wrap or clear; drives the next stage's step_dn |

## Verification
The checker's rules rely on step_up and step_dn being settled before each rising edge. They also rely on the count register starting at zero, because the block has no reset. The properties stay inactive until the first clock edge has passed, and a separate one-time check covers the starting value. The stimulus changes the request inputs only on falling edges. It exercises all four request combinations, including long runs of same-direction pulses that cross both wrap points. A four-stage chain in the bench confirms that carry, borrow and the clear reach every downstream stage.

// File: rtl/wcnt_pkg.sv
package wcnt_pkg;

   typedef enum logic [1:0] {
      OP_HOLD = 2'b00,
      OP_DEC  = 2'b01,
      OP_INC  = 2'b10,
      OP_CLR  = 2'b11
   } step_op_e;

   function automatic step_op_e op_from_req(input logic up, input logic dn);
      step_op_e op;
      unique case ({up, dn})
         2'b10:   op = OP_INC;
         2'b01:   op = OP_DEC;
         2'b11:   op = OP_CLR;
         default: op = OP_HOLD;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/wcnt_next.sv
module wcnt_next
   import wcnt_pkg::*;
#(
   parameter int MODULUS = 9,
   parameter int CNT_W   = $clog2(MODULUS)
) (
   input  step_op_e         op,
   input  logic [CNT_W-1:0] cur,
   output logic [CNT_W-1:0] nxt,
   output logic             carry,
   output logic             borrow
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);
   localparam bit FULL_RANGE = ((1 << CNT_W) == MODULUS);

   logic             at_top;
   logic             at_bot;
   logic [CNT_W-1:0] inc_val;
   logic [CNT_W-1:0] dec_val;

   assign at_bot = ~|cur;

   generate
      if (FULL_RANGE) begin : g_natural_wrap
         assign at_top  = &cur;
         assign inc_val = cur + 1'b1;
         assign dec_val = cur - 1'b1;
      end else begin : g_compare_wrap
         assign at_top  = (cur == LAST);
         assign inc_val = at_top ? '0 : cur + 1'b1;
         assign dec_val = at_bot ? LAST : cur - 1'b1;
      end
   endgenerate

   always_comb begin
      nxt    = cur;
      carry  = 1'b0;
      borrow = 1'b0;
      unique case (op)
         OP_INC: begin
            nxt   = inc_val;
            carry = at_top;
         end
         OP_DEC: begin
            nxt    = dec_val;
            borrow = at_bot;
         end
         OP_CLR: begin
            nxt    = '0;
            carry  = 1'b1;
            borrow = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/wcnt_state_reg.sv
module wcnt_state_reg #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] q_r = '0;

   always_ff @(posedge clk) begin
      q_r <= d;
   end

   assign q = q_r;

endmodule

// File: rtl/wrap_updn_stage.sv
module wrap_updn_stage
   import wcnt_pkg::*;
#(
   parameter int MODULUS = 9,
   localparam int CNT_W  = $clog2(MODULUS)
) (
   input  logic             clk,
   input  logic             step_up,
   input  logic             step_dn,
   output logic [CNT_W-1:0] count,
   output logic             carry,
   output logic             borrow
);

   generate
      if (MODULUS < 2) begin : g_bad_modulus
         $error("wrap_updn_stage: MODULUS must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_width
         $error("wrap_updn_stage: derived count width must be positive");
      end
   endgenerate

   step_op_e         op;
   logic [CNT_W-1:0] cur_q;
   logic [CNT_W-1:0] nxt_d;

   assign op = op_from_req(step_up, step_dn);

   wcnt_next #(
      .MODULUS (MODULUS),
      .CNT_W   (CNT_W)
   ) next_i (
      .op     (op),
      .cur    (cur_q),
      .nxt    (nxt_d),
      .carry  (carry),
      .borrow (borrow)
   );

   wcnt_state_reg #(
      .WIDTH (CNT_W)
   ) reg_i (
      .clk (clk),
      .d   (nxt_d),
      .q   (cur_q)
   );

   assign count = cur_q;

endmodule

// File: rtl/wrap_updn_stage_chk.sv
module wrap_updn_stage_chk #(
   parameter int MODULUS = 9,
   localparam int CNT_W  = $clog2(MODULUS)
) (
   input logic             clk,
   input logic             step_up,
   input logic             step_dn,
   input logic [CNT_W-1:0] count,
   input logic             carry,
   input logic             borrow
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   // R2
   always @(posedge clk) begin
      if (!armed) begin
         start_zero_chk: assert (count == '0 && !carry && !borrow);
      end
   end

   // R1
   count_range_chk: assert property (@(posedge clk) disable iff (!armed)
      int'(count) < MODULUS);

   // R3
   inc_step_chk: assert property (@(posedge clk) disable iff (!armed)
      (step_up && !step_dn && count != LAST) |=> count == CNT_W'($past(count) + 1'b1));

   // R4
   inc_wrap_chk: assert property (@(posedge clk) disable iff (!armed)
      (step_up && !step_dn && count == LAST) |=> count == '0);

   // R4
   carry_cause_chk: assert property (@(posedge clk) disable iff (!armed)
      carry |-> (step_up && (step_dn || count == LAST)));

   // R5
   dec_step_chk: assert property (@(posedge clk) disable iff (!armed)
      (step_dn && !step_up && count != '0) |=> count == CNT_W'($past(count) - 1'b1));

   // R6
   dec_wrap_chk: assert property (@(posedge clk) disable iff (!armed)
      (step_dn && !step_up && count == '0) |=> count == LAST);

   // R6
   borrow_cause_chk: assert property (@(posedge clk) disable iff (!armed)
      borrow |-> (step_dn && (step_up || count == '0)));

   // R7
   clear_next_chk: assert property (@(posedge clk) disable iff (!armed)
      (step_up && step_dn) |=> count == '0);

   // R7
   clear_flags_chk: assert property (@(posedge clk) disable iff (!armed)
      (step_up && step_dn) |-> (carry && borrow));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!armed)
      (!step_up && !step_dn) |=> $stable(count));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!armed)
      (!step_up && !step_dn) |-> (!carry && !borrow));

endmodule

bind wrap_updn_stage wrap_updn_stage_chk #(
   .MODULUS (MODULUS)
) chk_i (
   .clk     (clk),
   .step_up (step_up),
   .step_dn (step_dn),
   .count   (count),
   .carry   (carry),
   .borrow  (borrow)
);

// File: tb/wrap_updn_stage_tb_top.sv
module wrap_updn_stage_tb_top;

   localparam int MOD   = 9;
   localparam int W     = $clog2(MOD);
   localparam int NSTG  = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          up0 = 1'b0;
   logic          dn0 = 1'b0;
   logic [W-1:0]  cnt   [NSTG];
   logic          cy    [NSTG];
   logic          bw    [NSTG];

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // expected digit values, stage 0 first
   int model [NSTG];

   wrap_updn_stage #(.MODULUS(MOD)) dut_i (
      .clk (clk), .step_up (up0), .step_dn (dn0),
      .count (cnt[0]), .carry (cy[0]), .borrow (bw[0])
   );

   // R9: downstream stages chained carry->up, borrow->down
   for (genvar i = 1; i < NSTG; i++) begin : g_chain
      wrap_updn_stage #(.MODULUS(MOD)) stg_i (
         .clk (clk), .step_up (cy[i-1]), .step_dn (bw[i-1]),
         .count (cnt[i]), .carry (cy[i]), .borrow (bw[i])
      );
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // One request cycle: drive on falling edge, check flags, then counts.
   task automatic apply(input logic u, input logic d, input string req);
      logic eu, ed;
      int   nxt [NSTG];
      logic ecy [NSTG];
      logic ebw [NSTG];
      @(negedge clk);
      up0 = u;
      dn0 = d;
      eu = u;
      ed = d;
      for (int i = 0; i < NSTG; i++) begin
         ecy[i] = 1'b0;
         ebw[i] = 1'b0;
         nxt[i] = model[i];
         if (eu && ed) begin
            ecy[i] = 1'b1; ebw[i] = 1'b1; nxt[i] = 0;
         end else if (eu) begin
            ecy[i] = (model[i] == MOD - 1);
            nxt[i] = (model[i] == MOD - 1) ? 0 : model[i] + 1;
         end else if (ed) begin
            ebw[i] = (model[i] == 0);
            nxt[i] = (model[i] == 0) ? MOD - 1 : model[i] - 1;
         end
         eu = ecy[i];
         ed = ebw[i];
      end
      #1;
      check({req, " carry"},  int'(cy[0]), int'(ecy[0]));
      check({req, " borrow"}, int'(bw[0]), int'(ebw[0]));
      @(posedge clk);
      #1;
      for (int i = 0; i < NSTG; i++) model[i] = nxt[i];
      check({req, " count"}, int'(cnt[0]), model[0]);
      for (int i = 1; i < NSTG; i++) check("R9 chain count", int'(cnt[i]), model[i]);
      for (int i = 0; i < NSTG; i++)
         if (int'(cnt[i]) >= MOD) check("R1 range", int'(cnt[i]), MOD - 1);
   endtask

   task automatic t_power_up();
      #1;
      check("R2 count", int'(cnt[0]), 0);
      check("R2 carry", int'(cy[0]), 0);
      check("R2 borrow", int'(bw[0]), 0);
      for (int i = 0; i < NSTG; i++) model[i] = 0;
   endtask

   task automatic t_count_up();
      for (int k = 0; k < MOD - 1; k++) apply(1'b1, 1'b0, "R3");
      check("R4 at top", int'(cnt[0]), MOD - 1);
      apply(1'b1, 1'b0, "R4");
      check("R9 stage1 stepped", int'(cnt[1]), 1);
   endtask

   task automatic t_hold();
      for (int k = 0; k < 3; k++) apply(1'b0, 1'b0, "R8");
   endtask

   task automatic t_count_down();
      apply(1'b0, 1'b1, "R6");
      check("R6 wrap to top", int'(cnt[0]), MOD - 1);
      for (int k = 0; k < MOD - 1; k++) apply(1'b0, 1'b1, "R5");
      apply(1'b0, 1'b1, "R6");
   endtask

   task automatic t_clear();
      for (int k = 0; k < 5; k++) apply(1'b1, 1'b0, "R3");
      apply(1'b1, 1'b1, "R7");
      for (int i = 0; i < NSTG; i++) check("R9 all clear", int'(cnt[i]), 0);
   endtask

   task automatic t_chain_borrow();
      apply(1'b0, 1'b1, "R6");
      for (int i = 0; i < NSTG; i++) check("R9 borrow ripple", int'(cnt[i]), MOD - 1);
      apply(1'b1, 1'b0, "R4");
      for (int i = 0; i < NSTG; i++) check("R9 carry ripple", int'(cnt[i]), 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      t_power_up();
      t_count_up();
      t_hold();
      t_count_down();
      t_clear();
      t_chain_borrow();
      t_hold();
      @(negedge clk);
      up0 = 1'b0;
      dn0 = 1'b0;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

endmodule